// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether an incoming frame is kept, based on its 48-bit destination address. The receive path presents the six destination bytes together with a one-cycle valid strobe and a flag saying that the frame ended before a full address arrived. The filter classifies the address as broadcast, hashed (group or all-address hash mode) or unicast. It then reports two results: an accept decision for the storage logic, and a miss flag that is written into the receive descriptor.

Group addresses are looked up in a 64-entry hash table held in two 32-bit registers. The index is taken from the top bits of a CRC-32 computed inside the block. Unicast addresses are compared byte for byte with the programmed station address. A promiscuous mode keeps every frame but still reports whether the address would have been missed. The inputs are captured on the valid strobe. The verdict appears a fixed two cycles later and is held until the next verdict.

Top module: `rx_dest_filter`

## Requirements
- R1: During and after synchronous reset, `dec_valid`, `accept` and `miss` read 0 until the first verdict.
- R2: A verdict for an address sampled with `addr_valid` high at clock edge t appears after edge t+2. `dec_valid` is high for that one cycle only. `accept` and `miss` change only together with `dec_valid`, and they hold their value otherwise.
- R3: When `short_frame` is high, the address is a miss, whatever its bytes are.
- R4: An all-ones destination (all six bytes 0xFF) is a miss exactly when `bcast_reject` is 1. A broadcast never goes through the hash table.
- R5: For a non-broadcast address whose first byte (`dest_addr[7:0]`, byte i at `dest_addr[8*i+7:8*i]`) has bit 0 set, the block computes a CRC over the six bytes. The CRC uses polynomial 0x04C11DB7, start value 0xFFFFFFFF, each byte least significant bit first, and no final inversion. CRC bits 31:26 form an index k. The address hits if bit k of `hash_lo` (k < 32) or bit k-32 of `hash_hi` (k ≥ 32) is 1, and is a miss otherwise.
- R6: With `hash_all` set, a non-broadcast unicast address is also decided by the hash lookup of R5, and the station address is ignored.
- R7: Otherwise, a unicast address hits only when byte 0 equals `station_hi[15:8]`, byte 1 equals `station_hi[7:0]`, and bytes 2, 3, 4 and 5 equal `station_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R8: With `promisc` set, `accept` is 1 for every frame, and `miss` still reports the result of R3 to R7.
- R9: With `promisc` clear, `accept` is the inverse of `miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | One-cycle strobe: the address and the settings below are sampled |
| dest_addr | input | 48 | Destination bytes, byte 0 (first on the wire) in bits 7:0 |
| short_frame | input | 1 | Frame ended before six address bytes |
| station_hi | input | 16 | Station address bytes 0 and 1 |
| station_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash table bits 0 to 31 |
| hash_hi | input | 32 | Hash table bits 32 to 63 |
| bcast_reject | input | 1 | Treat broadcast as a miss |
| hash_all | input | 1 | Route unicast addresses through the hash table |
| promisc | input | 1 | Accept all frames, keep the miss flag |
| dec_valid | output | 1 | One-cycle pulse when a new verdict is presented |
| accept | output | 1 | Frame is to be stored |
| miss | output | 1 | Address did not match; for the descriptor |

## Verification
The bench builds the filter with its default parameters: six address bytes and a 6-bit hash index over two 32-bit table words. These values cover every table bit on both sides of the 32-bit split. The bench takes the hash index from its own bit-serial CRC. It then sets or clears exactly that table bit, so hits and misses in each word are driven on purpose rather than left to chance. Back-to-back strobes and randomly mixed addresses, modes and tables exercise the fixed two-cycle latency and the hold behaviour between verdicts.

// File: rtl/rx_filter_pkg.sv
// Package: shared constants, classification type and the CRC byte step
// used by the receive destination address filter.
package rx_filter_pkg;

    localparam int unsigned CRC_W    = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    // Which rule decided the address.
    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_HASH  = 2'd2,
        CLS_UCAST = 2'd3
    } addr_class_e;

    // Result pair carried to the output stage.
    typedef struct packed {
        logic accept;
        logic miss;
    } verdict_t;

    // Advance the CRC register by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[CRC_W-1] ^ data[b];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/rx_hash_crc.sv
// Module: rx_hash_crc
// Computes the CRC over the destination bytes and returns its top
// IDX_W bits as the hash table index.
// Assumes byte 0 sits in the lowest byte lane and is the first byte
// fed into the CRC. Purely combinational.
module rx_hash_crc
    import rx_filter_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned IDX_W      = 6
) (
    input  logic [8*ADDR_BYTES-1:0] dest,
    output logic [IDX_W-1:0]        idx
);

    logic [CRC_W-1:0] chain [0:ADDR_BYTES];

    assign chain[0] = CRC_SEED;

    // One CRC byte step per address byte, chained in wire order.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        assign chain[g+1] = crc_step_byte(chain[g], dest[8*g +: 8]);
    end

    // Index is taken from the most significant CRC bits.
    assign idx = chain[ADDR_BYTES][CRC_W-1 -: IDX_W];

endmodule

// File: rtl/rx_hash_lookup.sv
// Module: rx_hash_lookup
// Selects one bit of the hash table built from two words. Low indices
// address the low word; the rest address the high word.
// Assumes 2*WORD_W equals 2**IDX_W. Purely combinational.
module rx_hash_lookup #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] table_lo,
    input  logic [WORD_W-1:0] table_hi,
    input  logic [IDX_W-1:0]  idx,
    output logic              hit
);

    localparam int unsigned TABLE_BITS = 2 * WORD_W;
    localparam int unsigned SEL_W      = $clog2(WORD_W);

    logic             word_sel;
    logic [SEL_W-1:0] bit_sel;

    // Split the index into word select and bit position.
    always_comb begin
        word_sel = idx[IDX_W-1];
        bit_sel  = idx[SEL_W-1:0];
    end

    // Read the addressed table bit.
    always_comb begin
        hit = word_sel ? table_hi[bit_sel] : table_lo[bit_sel];
    end

    initial begin
        if (TABLE_BITS != (1 << IDX_W)) begin
            $display("rx_hash_lookup: table size does not match index width");
        end
    end

endmodule

// File: rtl/rx_station_match.sv
// Module: rx_station_match
// Exact comparison of the destination with the programmed station
// address. Station byte 0 is the top byte of station_hi. Later bytes
// follow towards station_lo bit 0.
// Assumes ADDR_BYTES > 4 so that station_lo holds four bytes.
// Purely combinational.
module rx_station_match #(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic [8*ADDR_BYTES-1:0]  dest,
    input  logic [8*ADDR_BYTES-33:0] station_hi,
    input  logic [31:0]              station_lo,
    output logic                     hit
);

    localparam int unsigned ADDR_W = 8 * ADDR_BYTES;

    logic [ADDR_W-1:0]     station;
    logic [ADDR_BYTES-1:0] byte_eq;

    // Join the two registers with byte 0 at the top.
    assign station = {station_hi, station_lo};

    // Per-byte equality, byte i against station byte i from the top.
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
        assign byte_eq[i] = (dest[8*i +: 8] == station[ADDR_W-1-8*i -: 8]);
    end

    // All bytes must agree.
    assign hit = &byte_eq;

endmodule

// File: rtl/rx_filter_decide.sv
// Module: rx_filter_decide
// Picks the rule that applies to the address and forms the verdict.
// Priority: short frame, broadcast, hash (group bit or hash_all), unicast.
// Promiscuous mode forces accept and leaves miss untouched.
// Purely combinational.
module rx_filter_decide
    import rx_filter_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic [8*ADDR_BYTES-1:0] dest,
    input  logic                    short_frame,
    input  logic                    hash_hit,
    input  logic                    station_hit,
    input  logic                    bcast_reject,
    input  logic                    hash_all,
    input  logic                    promisc,
    output addr_class_e             cls,
    output verdict_t                verdict
);

    logic is_bcast;
    logic is_group;
    logic missed;

    // Address shape.
    always_comb begin
        is_bcast = &dest;
        is_group = dest[0];
    end

    // Choose the deciding rule by priority.
    always_comb begin
        if (short_frame) begin
            cls = CLS_SHORT;
        end else if (is_bcast) begin
            cls = CLS_BCAST;
        end else if (is_group || hash_all) begin
            cls = CLS_HASH;
        end else begin
            cls = CLS_UCAST;
        end
    end

    // Miss result of the chosen rule.
    always_comb begin
        unique case (cls)
            CLS_SHORT: missed = 1'b1;
            CLS_BCAST: missed = bcast_reject;
            CLS_HASH:  missed = ~hash_hit;
            CLS_UCAST: missed = ~station_hit;
            default:   missed = 1'b1;
        endcase
    end

    // Final verdict with promiscuous override.
    always_comb begin
        verdict.miss   = missed;
        verdict.accept = ~missed | promisc;
    end

endmodule

// File: rtl/rx_dest_filter.sv
// Module: rx_dest_filter (top)
// Receive destination address filter. Stage 1 captures the address and
// all settings on addr_valid. Stage 2 evaluates the CRC hash, station
// compare and rule priority, and registers the verdict. The verdict is
// held until the next one. Synchronous active-low reset.
module rx_dest_filter
    import rx_filter_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned WORD_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     addr_valid,
    input  logic [8*ADDR_BYTES-1:0]  dest_addr,
    input  logic                     short_frame,
    input  logic [8*ADDR_BYTES-33:0] station_hi,
    input  logic [31:0]              station_lo,
    input  logic [WORD_W-1:0]        hash_lo,
    input  logic [WORD_W-1:0]        hash_hi,
    input  logic                     bcast_reject,
    input  logic                     hash_all,
    input  logic                     promisc,
    output logic                     dec_valid,
    output logic                     accept,
    output logic                     miss
);

    localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
    localparam int unsigned STHI_W = ADDR_W - 32;

    // Stage 1 captured state.
    logic              s1_valid;
    logic [ADDR_W-1:0] s1_dest;
    logic              s1_short;
    logic [STHI_W-1:0] s1_st_hi;
    logic [31:0]       s1_st_lo;
    logic [WORD_W-1:0] s1_hash_lo;
    logic [WORD_W-1:0] s1_hash_hi;
    logic              s1_brej;
    logic              s1_hall;
    logic              s1_prom;

    // Stage 2 evaluation signals.
    logic [IDX_W-1:0]  hash_idx;
    logic              hash_hit;
    logic              station_hit;
    addr_class_e       cls;
    verdict_t          verdict;

    // Stage 1: track the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= addr_valid;
        end
    end

    // Stage 1: capture the address and settings on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_dest    <= '0;
            s1_short   <= 1'b0;
            s1_st_hi   <= '0;
            s1_st_lo   <= '0;
            s1_hash_lo <= '0;
            s1_hash_hi <= '0;
            s1_brej    <= 1'b0;
            s1_hall    <= 1'b0;
            s1_prom    <= 1'b0;
        end else if (addr_valid) begin
            s1_dest    <= dest_addr;
            s1_short   <= short_frame;
            s1_st_hi   <= station_hi;
            s1_st_lo   <= station_lo;
            s1_hash_lo <= hash_lo;
            s1_hash_hi <= hash_hi;
            s1_brej    <= bcast_reject;
            s1_hall    <= hash_all;
            s1_prom    <= promisc;
        end
    end

    rx_hash_crc #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_crc (
        .dest (s1_dest),
        .idx  (hash_idx)
    );

    rx_hash_lookup #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_lookup (
        .table_lo (s1_hash_lo),
        .table_hi (s1_hash_hi),
        .idx      (hash_idx),
        .hit      (hash_hit)
    );

    rx_station_match #(
        .ADDR_BYTES (ADDR_BYTES)
    ) u_station (
        .dest       (s1_dest),
        .station_hi (s1_st_hi),
        .station_lo (s1_st_lo),
        .hit        (station_hit)
    );

    rx_filter_decide #(
        .ADDR_BYTES (ADDR_BYTES)
    ) u_decide (
        .dest         (s1_dest),
        .short_frame  (s1_short),
        .hash_hit     (hash_hit),
        .station_hit  (station_hit),
        .bcast_reject (s1_brej),
        .hash_all     (s1_hall),
        .promisc      (s1_prom),
        .cls          (cls),
        .verdict      (verdict)
    );

    // Stage 2: pulse dec_valid one cycle after capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= s1_valid;
        end
    end

    // Stage 2: register the verdict and hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            miss   <= 1'b0;
        end else if (s1_valid) begin
            accept <= verdict.accept;
            miss   <= verdict.miss;
        end
    end

endmodule

// File: rtl/rx_dest_filter_chk.sv
// Module: rx_dest_filter_chk
// Assertion checker bound to rx_dest_filter. It observes ports only.
module rx_dest_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_valid,
    input logic [47:0] dest_addr,
    input logic        short_frame,
    input logic        bcast_reject,
    input logic        promisc,
    input logic        dec_valid,
    input logic        accept,
    input logic        miss
);

    // Verdict pulse follows the strobe by exactly two edges.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == $past(addr_valid, 2));

    // Outputs hold between verdicts.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> ($stable(accept) && $stable(miss)));

    // A short frame always yields a miss.
    assert_short_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid && short_frame, 2) |-> miss);

    // Rejected broadcast yields a miss.
    assert_bcast_rej_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid && !short_frame && (&dest_addr) && bcast_reject, 2) |-> miss);

    // Promiscuous mode always accepts.
    assert_promisc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid && promisc, 2) |-> accept);

    // Without promiscuous mode accept and miss are complementary.
    assert_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid && !promisc, 2) |-> (accept != miss));

endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid   (addr_valid),
    .dest_addr    (dest_addr),
    .short_frame  (short_frame),
    .bcast_reject (bcast_reject),
    .promisc      (promisc),
    .dec_valid    (dec_valid),
    .accept       (accept),
    .miss         (miss)
);

// File: tb/rx_dest_filter_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module rx_dest_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [47:0] dest_addr = '0;
    logic        short_frame = 1'b0;
    logic [15:0] station_hi = '0;
    logic [31:0] station_lo = '0;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic        bcast_reject = 1'b0;
    logic        hash_all = 1'b0;
    logic        promisc = 1'b0;
    logic        dec_valid;
    logic        accept;
    logic        miss;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    rx_dest_filter u_dut (
        .clk (clk), .rst_n (rst_n), .addr_valid (addr_valid),
        .dest_addr (dest_addr), .short_frame (short_frame),
        .station_hi (station_hi), .station_lo (station_lo),
        .hash_lo (hash_lo), .hash_hi (hash_hi),
        .bcast_reject (bcast_reject), .hash_all (hash_all), .promisc (promisc),
        .dec_valid (dec_valid), .accept (accept), .miss (miss)
    );

    // Bit-serial CRC index from the requirement text.
    function automatic int ref_index(input logic [47:0] a);
        int unsigned r;
        int unsigned bt;
        r = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            bt = a[8*i +: 8];
            for (int b = 0; b < 8; b++) begin
                if ((((r >> 31) & 1) ^ ((bt >> b) & 1)) != 0)
                    r = (r << 1) ^ 32'h04C11DB7;
                else
                    r = r << 1;
            end
        end
        return int'(r >> 26);
    endfunction

    // Reference decision; tag names the rule that decided it.
    function automatic void ref_eval(output bit acc, output bit ms, output string tag);
        int k;
        bit hit;
        bit is_b;
        is_b = (dest_addr == 48'hFFFF_FFFF_FFFF);
        if (short_frame) begin
            ms = 1; tag = "R3";
        end else if (is_b) begin
            ms = bcast_reject; tag = "R4";
        end else if (dest_addr[0] || hash_all) begin
            k = ref_index(dest_addr);
            hit = (k < 32) ? hash_lo[k] : hash_hi[k - 32];
            ms = !hit;
            tag = dest_addr[0] ? "R5" : "R6";
        end else begin
            hit = (dest_addr[7:0]   == station_hi[15:8]) && (dest_addr[15:8]  == station_hi[7:0]) &&
                  (dest_addr[23:16] == station_lo[31:24]) && (dest_addr[31:24] == station_lo[23:16]) &&
                  (dest_addr[39:32] == station_lo[15:8]) && (dest_addr[47:40] == station_lo[7:0]);
            ms = !hit; tag = "R7";
        end
        if (promisc) begin
            acc = 1; tag = "R8";
        end else begin
            acc = !ms;
            if (ms && tag == "R7") tag = "R9";
        end
    endfunction

    // Model pipeline: stage of capture, then verdict register.
    bit    m1_v, m1_acc, m1_miss, m2_v, h_acc, h_miss;
    string m1_tag, h_tag;
    always @(posedge clk) begin
        bit    a_acc, a_ms;
        string a_tag;
        if (!rst_n) begin
            m1_v <= 0; m2_v <= 0; h_acc <= 0; h_miss <= 0; h_tag <= "R1";
        end else begin
            m1_v <= addr_valid;
            if (addr_valid) begin
                ref_eval(a_acc, a_ms, a_tag);
                m1_acc <= a_acc; m1_miss <= a_ms; m1_tag <= a_tag;
            end
            m2_v <= m1_v;
            if (m1_v) begin
                h_acc <= m1_acc; h_miss <= m1_miss; h_tag <= m1_tag;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", "dec_valid", int'(dec_valid), int'(m2_v));
            check(h_tag, "accept", int'(accept), int'(h_acc));
            check(h_tag, "miss", int'(miss), int'(h_miss));
        end
    end

    task automatic send(input logic [47:0] a, input bit sh, input int gap);
        @(negedge clk);
        dest_addr = a; short_frame = sh; addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [47:0] mc;
        int k;
        repeat (3) @(negedge clk);
        // R1: outputs low while in reset
        check("R1", "dec_valid in reset", int'(dec_valid), 0);
        check("R1", "accept in reset", int'(accept), 0);
        check("R1", "miss in reset", int'(miss), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "accept after reset", int'(accept), 0);

        station_hi = 16'h0211; station_lo = 32'h2233_4455;
        // R7: exact station match and single-byte mismatches
        send(48'h5544_3322_1102, 0, 3);
        check("R7", "station hit accept", int'(accept), 1);
        for (int i = 0; i < 6; i++) send(48'h5544_3322_1102 ^ (48'h10 << (8*i)), 0, 2);
        // R3: short frame, even with a matching address
        send(48'h5544_3322_1102, 1, 3);
        check("R3", "short miss", int'(miss), 1);
        // R4: broadcast both ways
        bcast_reject = 0; send(48'hFFFF_FFFF_FFFF, 0, 3);
        check("R4", "bcast accepted", int'(miss), 0);
        bcast_reject = 1; send(48'hFFFF_FFFF_FFFF, 0, 3);
        check("R4", "bcast rejected", int'(miss), 1);
        // R5: single table bit at the computed index, low and high words
        for (int t = 0; t < 40; t++) begin
            mc = {$urandom, $urandom}; mc[0] = 1'b1;
            k = ref_index(mc);
            hash_lo = '0; hash_hi = '0;
            if (k < 32) hash_lo[k] = 1'b1; else hash_hi[k-32] = 1'b1;
            send(mc, 0, 2);
            check("R5", "group single-bit hit", int'(miss), 0);
            hash_lo = ~hash_lo; hash_hi = ~hash_hi;
            send(mc, 0, 2);
            check("R5", "group single-bit miss", int'(miss), 1);
        end
        // R6: unicast through hash, station ignored
        hash_all = 1; hash_lo = '0; hash_hi = '0;
        send(48'h5544_3322_1102, 0, 3);
        check("R6", "hash_all miss despite station match", int'(miss), 1);
        hash_lo = '1; hash_hi = '1;
        send(48'h0000_0000_0010, 0, 3);
        check("R6", "hash_all hit", int'(miss), 0);
        hash_all = 0;
        // R8: promiscuous keeps miss flag
        promisc = 1; send(48'h0000_0000_0010, 0, 3);
        check("R8", "promisc accept", int'(accept), 1);
        check("R8", "promisc miss kept", int'(miss), 1);
        promisc = 0;
        // R2: back-to-back strobes
        for (int i = 0; i < 8; i++) send(i[0] ? 48'h5544_3322_1102 : 48'h0000_0000_0020, 0, 0);
        repeat (4) @(negedge clk);
        // Random mix
        for (int t = 0; t < 600; t++) begin
            case ($urandom % 5)
                0: mc = 48'hFFFF_FFFF_FFFF;
                1: mc = {station_lo[7:0], station_lo[15:8], station_lo[23:16],
                         station_lo[31:24], station_hi[7:0], station_hi[15:8]};
                default: mc = {$urandom, $urandom};
            endcase
            hash_lo = $urandom; hash_hi = $urandom;
            bcast_reject = $urandom; hash_all = ($urandom % 4) == 0;
            promisc = ($urandom % 4) == 0;
            send(mc, ($urandom % 8) == 0, $urandom % 3);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule